// File: doc/BRIEF.md
# Prime-length seven-point DFT engine

This block computes a seven-point discrete Fourier transform of real, signed fixed-point samples. Samples arrive one at a time on a valid/ready stream, in natural index order. After the seventh sample of a frame, the block starts the frame's computation. It sends out seven complex bins, X[0] through X[6], on consecutive cycles. A flag marks bin 0.

Seven is prime, so the six non-zero indices form a cyclic group generated by 3. The block reorders x[1..6] by successive powers of 3, which gives x[1], x[3], x[2], x[6], x[4], x[5]. This turns the six non-DC bins into a length-6 cyclic correlation with a fixed kernel. A transposed-form, rotating accumulator bank computes the correlation. It is fed by one shared constant-multiplier block. That block uses only shifts and adds, in canonic signed-digit form, and is split over two register stages. Each accumulator starts at x[0] scaled by 2^12. A running sum taken while the samples arrive gives X[0] directly.

The kernel coefficients are 12-bit magnitudes plus sign, with a scale of 4096. The accumulators are double width. Results are rounded to the output width once, at the end. The next frame can be collected while the previous frame is still being computed or sent out.

Top module: `rader7_dft`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and out_first is 0.
- R2: A sample is taken on each rising edge with in_valid and in_ready both 1.
  - The seven samples of a frame are x[0]..x[6] in order of arrival.
  - In the cycle after the seventh sample is taken, in_ready is 0.
  - in_ready returns to 1 once the frame's computation has started; this happens one cycle later when the engine is idle.
- R3: Bin 0 appears with out_first = 1. Its out_re is the exact sum of the seven samples and its out_im is 0.
- R4: Bin b (1..6) is bit-exact: out_re = (4096·x[0] + Σ_{n=1..6} x[n]·Cr[(n·b) mod 7] + 2048) >> 12, where >> is an arithmetic shift.
  - out_im is the same expression with x[0] replaced by 0 and Cr replaced by Ci.
  - Cr[e] = round(4096·cos(2πe/7)) and Ci[e] = −round(4096·sin(2πe/7)), rounding half away from zero.
- R5: Each accepted frame produces one burst of seven bins in natural order 0..6 on consecutive cycles. out_first is 1 only on bin 0. Bursts leave in frame order.
- R6: Inputs anywhere in the full signed DW-bit range give correct results with no wrap. The output width of DW+3 bits holds every result.
- R7: The next frame may be collected while the previous one is computed or sent out. The next frame's computation starts only after the previous burst has ended. Both frames are correct whatever the offset between them.
- R8: Idle cycles on in_valid inside a frame do not change its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present on in_data |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | A bin is present on out_re/out_im |
| out_first | output | 1 | The present bin is bin 0 |
| out_re | output | DW+3 | Signed real part of the bin |
| out_im | output | DW+3 | Signed imaginary part of the bin |

## Verification
Two functions can fall in the same cycle. One is the next frame's final sample being taken and added into the running DC sum. The other is the previous frame's bins leaving, including the DC value captured from that sum. The bench provokes this by sending pairs of frames with the idle gap between them swept from zero to twelve cycles, so that the last sample lands before, on and after each bin of the previous burst. Both frames are judged bin by bit-exact bin against a scoreboard model built from the cosine/sine formula. A check on in_ready right after a frame confirms the hold-off.

// File: rtl/rader7_dft.sv
module rader7_dft #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic                 out_first,
  output logic signed [DW+2:0] out_re,
  output logic signed [DW+2:0] out_im
);
  localparam int NPT = 7;
  localparam int NC  = NPT - 1;
  localparam int GEN = 3;
  localparam int FR  = 12;
  localparam int OW  = DW + 3;
  localparam int AW  = 2 * DW + 4;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FR - 1);

  function automatic int gpow(input int k);
    int r = 1;
    for (int i = 0; i < k; i++) r = (r * GEN) % NPT;
    return r;
  endfunction

  logic [2:0]             cnt;
  logic signed [DW-1:0]   xb [NPT];
  logic signed [OW-1:0]   dc, dc_h;
  logic signed [DW-1:0]   sh [NC];
  logic [2:0]             fcnt, ecnt, bin, jsel;
  logic                   v1, v2, accept, busy, start;
  logic signed [AW-1:0]   ax;
  logic signed [AW-1:0]   pa [NC], pb [NC], pr [NC];
  logic signed [AW-1:0]   tre [NC], tim [NC];
  logic signed [AW-1:0]   acc_re [NC], acc_im [NC];
  logic signed [AW-1:0]   rr, ri;

  assign in_ready = cnt != 3'd7;
  assign accept   = in_valid && in_ready;
  assign busy     = fcnt != 3'd0 || v1 || v2 || ecnt != 3'd0;
  assign start    = cnt == 3'd7 && !busy;

  // sample collection and running DC sum
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      dc  <= '0;
    end else if (start) begin
      cnt <= '0;
    end else if (accept) begin
      cnt <= cnt + 3'd1;
      dc  <= (cnt == 3'd0) ? OW'(in_data) : dc + OW'(in_data);
    end
  end

  always_ff @(posedge clk)
    if (accept) xb[cnt] <= in_data;

  // generator-order permutation into the feed register
  always_ff @(posedge clk) begin
    if (!rst_n) fcnt <= '0;
    else if (start) fcnt <= 3'(NC);
    else if (fcnt != 3'd0) fcnt <= fcnt - 3'd1;
  end

  always_ff @(posedge clk) begin
    if (start) begin
      for (int i = 0; i < NC; i++) sh[i] <= xb[gpow(i)];
    end else if (fcnt != 3'd0) begin
      for (int i = 0; i < NC - 1; i++) sh[i] <= sh[i+1];
    end
  end

  // shared shift-add multiplier block, two stages
  assign ax = AW'(sh[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= fcnt != 3'd0;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    pa[0] <= (ax <<< 11) + (ax <<< 9);  pb[0] <= (ax <<< 1) - (ax <<< 3);
    pa[1] <= (ax <<< 10) - (ax <<< 7);  pb[1] <= (ax <<< 4) - ax;
    pa[2] <= (ax <<< 12) - (ax <<< 9);  pb[2] <= (ax <<< 7) - (ax <<< 5) + (ax <<< 3) + (ax <<< 1);
    pa[3] <= (ax <<< 12) - (ax <<< 10); pb[3] <= (ax <<< 7) + (ax <<< 1);
    pa[4] <= (ax <<< 12) - (ax <<< 7);  pb[4] <= (ax <<< 5) - (ax <<< 3) + ax;
    pa[5] <= (ax <<< 11) - (ax <<< 8);  pb[5] <= ax - (ax <<< 4);
    for (int i = 0; i < NC; i++) pr[i] <= pa[i] + pb[i];
  end

  // kernel W^(3^m): products 2554,911,3690,3202,3993,1777 with signs
  assign tre[0] =  pr[0]; assign tim[0] = -pr[3];
  assign tre[1] = -pr[2]; assign tim[1] = -pr[5];
  assign tre[2] = -pr[1]; assign tim[2] = -pr[4];
  assign tre[3] =  pr[0]; assign tim[3] =  pr[3];
  assign tre[4] = -pr[2]; assign tim[4] =  pr[5];
  assign tre[5] = -pr[1]; assign tim[5] =  pr[4];

  // rotating transposed accumulators, preloaded with x[0]
  always_ff @(posedge clk) begin
    if (start) begin
      dc_h <= dc;
      for (int j = 0; j < NC; j++) begin
        acc_re[j] <= AW'(xb[0]) <<< FR;
        acc_im[j] <= '0;
      end
    end else if (v2) begin
      for (int j = 0; j < NC; j++) begin
        acc_re[j] <= acc_re[(j + NC - 1) % NC] + tre[(j + NC - 1) % NC];
        acc_im[j] <= acc_im[(j + NC - 1) % NC] + tim[(j + NC - 1) % NC];
      end
    end
  end

  // natural-order emission
  assign bin = 3'd7 - ecnt;

  always_comb begin
    jsel = '0;
    for (int k = 0; k < NC; k++)
      if (int'(bin) == gpow(k)) jsel = 3'(k);
  end

  assign rr = (acc_re[jsel] + HALF) >>> FR;
  assign ri = (acc_im[jsel] + HALF) >>> FR;

  always_ff @(posedge clk) begin
    if (!rst_n) ecnt <= '0;
    else if (v2 && !v1) ecnt <= 3'd7;
    else if (ecnt != 3'd0) ecnt <= ecnt - 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= ecnt != 3'd0;
      out_first <= ecnt == 3'd7;
      out_re    <= (bin == 3'd0) ? dc_h : OW'(rr);
      out_im    <= (bin == 3'd0) ? '0   : OW'(ri);
    end
  end

  assert_dc_imag_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_im == '0);
  assert_burst_opens_with_dc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_first);
  assert_burst_continues_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |=> out_valid && !out_first);
  assert_no_accum_during_emit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> ecnt == 3'd0);
endmodule

// File: tb/tb_rader7_dft.sv
`timescale 1ns/1ps
module tb_rader7_dft;
  localparam int DW = 12;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_first;
  logic signed [DW+2:0] out_re, out_im;

  rader7_dft #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_first(out_first),
    .out_re(out_re), .out_im(out_im));

  always #2.5 clk = ~clk;

  typedef struct { int re; int im; bit first; int frame; int bin; string tag; } exp_t;
  exp_t q[$];
  int nchk = 0, nfail = 0, nframe = 0;
  int unsigned seed = 32'h1234_5678;
  bit done = 1'b0;

  function automatic int qround(input real v);
    return (v >= 0.0) ? int'($floor(v + 0.5)) : -int'($floor(-v + 0.5));
  endfunction

  function automatic int cre(input int e);
    return qround(4096.0 * $cos(2.0 * PI * e / 7.0));
  endfunction

  function automatic int cim(input int e);
    return -qround(4096.0 * $sin(2.0 * PI * e / 7.0));
  endfunction

  function automatic int next_sample();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 4096) - 2048;
  endfunction

  task automatic check(input string tag, input bit ok, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic put(input int v);
    in_valid = 1'b1;
    in_data  = DW'(v);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_frame(input int x[7], input int gap, input string tag);
    longint sr, si;
    for (int b = 0; b < 7; b++) begin
      exp_t e;
      if (b == 0) begin
        e.re = 0;
        for (int n = 0; n < 7; n++) e.re += x[n];
        e.im = 0;
        e.tag = "R3";
      end else begin
        sr = 4096 * longint'(x[0]);
        si = 0;
        for (int n = 1; n < 7; n++) begin
          sr += longint'(x[n]) * cre((n * b) % 7);
          si += longint'(x[n]) * cim((n * b) % 7);
        end
        e.re = int'((sr + 2048) >>> 12);
        e.im = int'((si + 2048) >>> 12);
        e.tag = tag;
      end
      e.first = (b == 0);
      e.frame = nframe;
      e.bin = b;
      q.push_back(e);
    end
    nframe++;
    for (int n = 0; n < 7; n++) begin
      put(x[n]);
      if (gap > 0 && n < 6) begin
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300 && q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      if (q.size() == 0) begin
        check("R5", 1'b0, "unexpected bin", int'(out_re), 0);
      end else begin
        e = q.pop_front();
        check(e.tag, int'(out_re) == e.re && int'(out_im) == e.im,
              $sformatf("frame %0d bin %0d re/im (im actual %0d expected %0d)",
                        e.frame, e.bin, int'(out_im), e.im),
              int'(out_re), e.re);
        check("R5", out_first == e.first,
              $sformatf("frame %0d bin %0d out_first", e.frame, e.bin),
              int'(out_first), int'(e.first));
      end
    end
  end

  initial begin
    int x[7];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", in_ready == 1'b1, "in_ready after reset", int'(in_ready), 1);
    check("R1", out_valid == 1'b0, "out_valid after reset", int'(out_valid), 0);
    check("R1", out_first == 1'b0, "out_first after reset", int'(out_first), 0);

    // impulse at x[0]: every bin equals x[0]
    x = '{100, 0, 0, 0, 0, 0, 0};
    send_frame(x, 0, "R4");
    check("R2", in_ready == 1'b0, "in_ready after seventh sample", int'(in_ready), 0);
    @(negedge clk);
    check("R2", in_ready == 1'b1, "in_ready after frame start", int'(in_ready), 1);
    drain();

    x = '{1, 2, 3, 4, 5, 6, 7};
    send_frame(x, 0, "R4");
    x = '{0, 1000, 0, 0, 0, 0, 0};
    send_frame(x, 0, "R4");
    x = '{0, 0, 0, 0, 0, 0, -777};
    send_frame(x, 0, "R4");
    drain();

    // full-scale extremes
    x = '{-2048, -2048, -2048, -2048, -2048, -2048, -2048};
    send_frame(x, 0, "R6");
    x = '{2047, 2047, 2047, 2047, 2047, 2047, 2047};
    send_frame(x, 0, "R6");
    for (int n = 0; n < 7; n++) x[n] = ($cos(2.0 * PI * n / 7.0) >= 0.0) ? 2047 : -2048;
    send_frame(x, 0, "R6");
    for (int n = 0; n < 7; n++) x[n] = ($sin(2.0 * PI * 3 * n / 7.0) >= 0.0) ? -2048 : 2047;
    send_frame(x, 0, "R6");
    drain();

    // idle cycles inside a frame
    for (int n = 0; n < 7; n++) x[n] = next_sample();
    send_frame(x, 3, "R8");
    for (int n = 0; n < 7; n++) x[n] = next_sample();
    send_frame(x, 1, "R8");
    drain();

    // frame pairs with a swept offset: collection overlaps the previous burst
    for (int d = 0; d <= 12; d++) begin
      for (int n = 0; n < 7; n++) x[n] = next_sample();
      send_frame(x, 0, "R7");
      repeat (d) @(negedge clk);
      for (int n = 0; n < 7; n++) x[n] = next_sample();
      send_frame(x, 0, "R7");
    end
    drain();

    for (int f = 0; f < 20; f++) begin
      for (int n = 0; n < 7; n++) x[n] = next_sample();
      send_frame(x, f % 3, "R4");
    end
    drain();

    check("R5", q.size() == 0, "bins still outstanding", q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL R5 watchdog expired actual=%0d pending expected=0", q.size());
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule